// File: doc/BRIEF.md
# Dual-Core Lockstep Error Containment Checker

This block stands between two identical processor cores that run the same instruction stream in lockstep and the system that consumes their bus traffic. Each cycle it compares the two cores' outgoing buses: the valid flag, address, write data and control strobes. The moment the two disagree, it freezes both cores and suppresses the outgoing valid in that same cycle, so a corrupted beat never reaches the system.

After a detected disagreement the block runs a recovery sequence. It moves through four states: RUN, HALT, RECOVER and RESYNC. In RECOVER it drives either a rollback request, which returns both cores to a saved checkpoint, or a reboot request. A mode input selects which request is used. In RESYNC it waits until both cores report that they are ready, and then returns to RUN.

The comparator and the recovery state machine are each built three times, and majority voters combine the three copies. Any disagreement among the copies is reported on a checker-fault flag. A saturating counter records the number of detected disagreements.

Top module: `lockstep_guard`

States and transitions:
- RUN → HALT when the voted comparator reports a mismatch.
- HALT → RECOVER always, after one cycle. The recovery mode and length are sampled on this transition.
- RECOVER → RECOVER while the remaining-cycle count is above 1.
- RECOVER → RESYNC when the count reaches 1.
- RESYNC → RESYNC while either core is not ready.
- RESYNC → RUN when both cores are ready.

## Requirements
- R1: A mismatch exists in a cycle when `a_vld` differs from `b_vld`, or when both are 1 and any of address, write data or control differ. When both valids are 0, differences in the data fields are ignored.
- R2: In RUN, a mismatch raises `core_halt` and forces `sys_vld` to 0 combinationally in the same cycle.
- R3: `sys_vld` is 1 only in RUN, and only for a matched beat with valid set. `sys_addr`, `sys_wdata` and `sys_ctl` carry core A's fields on a passed beat. Otherwise they hold the fields of the last passed beat, which are 0 after reset.
- R4: HALT lasts exactly one cycle, with `core_halt` high, and is always followed by RECOVER. `recov_mode` and `recov_len` are sampled on the cycle spent in HALT.
- R5: RECOVER lasts max(`recov_len`,1) cycles. During RECOVER, `core_rollback` is high when the sampled mode is 0 and `core_reboot` is high when the sampled mode is 1. The two requests are never high together, and both are low in every other state.
- R6: RESYNC drives `sys_vld` and `core_halt` low. It stays in RESYNC until `a_ready` and `b_ready` are both 1 at a clock edge, and then enters RUN. Mismatches seen outside RUN are neither counted nor acted on.
- R7: `err_count` increments by one on each clock edge at which RUN sees a mismatch. It saturates at its all-ones value.
- R8: Three comparator copies and three state-machine copies are combined by majority vote. `chk_fault` is 1 in any cycle in which the copies disagree, and is 0 in a fault-free design.
- R9: During and after reset the block is in RUN, with `err_count` at 0, `core_halt`, `core_rollback`, `core_reboot`, `sys_vld` and `chk_fault` at 0, and the held output fields at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Core A bus valid |
| a_addr | input | ADDR_W | Core A address |
| a_wdata | input | DATA_W | Core A write data |
| a_ctl | input | CTL_W | Core A control strobes |
| b_vld | input | 1 | Core B bus valid |
| b_addr | input | ADDR_W | Core B address |
| b_wdata | input | DATA_W | Core B write data |
| b_ctl | input | CTL_W | Core B control strobes |
| a_ready | input | 1 | Core A ready after recovery |
| b_ready | input | 1 | Core B ready after recovery |
| recov_mode | input | 1 | Recovery type: 0 rollback, 1 reboot |
| recov_len | input | LEN_W | Number of cycles the recovery request is held |
| sys_vld | output | 1 | Valid towards the system |
| sys_addr | output | ADDR_W | Address towards the system |
| sys_wdata | output | DATA_W | Write data towards the system |
| sys_ctl | output | CTL_W | Control strobes towards the system |
| core_halt | output | 1 | Freeze request to both cores |
| core_rollback | output | 1 | Checkpoint rollback request |
| core_reboot | output | 1 | Reboot request |
| err_count | output | CNT_W | Saturating mismatch count |
| chk_fault | output | 1 | Disagreement among the triplicated checker copies |

## Verification
The in-line assertions check, on every cycle:
- that a mismatch in RUN halts the cores and blocks `sys_vld` at once;
- that blocked outputs stay stable;
- that HALT is always followed by RECOVER;
- that the two recovery requests are exclusive;
- that the counter only moves from RUN and holds at saturation;
- that the voted copies agree.

Only the bench's scenarios can show the rest:
- that the recovery length and mode actually follow the sampled inputs;
- that RESYNC waits for both ready signals;
- that data on an invalid beat is ignored;
- that a narrow counter saturates after many errors.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALT    = 2'd1,
        ST_RECOVER = 2'd2,
        ST_RESYNC  = 2'd3
    } lsg_state_e;
endpackage

// File: rtl/lsg_cmp.sv
module lsg_cmp #(
    parameter int W = 8
) (
    input  logic         a_vld,
    input  logic         b_vld,
    input  logic [W-1:0] a_bus,
    input  logic [W-1:0] b_bus,
    output logic         mism
);
    // Data fields only matter when both cores present a beat (R1)
    always_comb begin
        mism = (a_vld != b_vld) || (a_vld && b_vld && (a_bus != b_bus));
    end
endmodule

// File: rtl/lsg_ctrl.sv
module lsg_ctrl
    import lsg_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip,
    input  logic             mode_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             rdy_ok,
    input  lsg_state_e       st_v,
    input  logic [LEN_W-1:0] cnt_v,
    input  logic             mode_v,
    output lsg_state_e       st_q,
    output logic [LEN_W-1:0] cnt_q,
    output logic             mode_q
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    lsg_state_e       st_d;
    logic [LEN_W-1:0] cnt_d;
    logic             mode_d;

    // Next state is computed from the voted copy so all replicas reconverge
    always_comb begin
        st_d   = st_v;
        cnt_d  = cnt_v;
        mode_d = mode_v;
        unique case (st_v)
            ST_RUN: begin
                if (trip) st_d = ST_HALT;
            end
            ST_HALT: begin
                st_d   = ST_RECOVER;
                mode_d = mode_in;
                cnt_d  = (len_in == '0) ? ONE : len_in;
            end
            ST_RECOVER: begin
                if (cnt_v <= ONE) st_d = ST_RESYNC;
                else              cnt_d = cnt_v - ONE;
            end
            ST_RESYNC: begin
                if (rdy_ok) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            mode_q <= mode_d;
        end
    end

    // R4
    halt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v == ST_HALT) |=> (st_q == ST_RECOVER));

    // R5
    recover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v == ST_RECOVER && cnt_v > ONE) |=> (st_q == ST_RECOVER));
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
    import lsg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CTL_W  = 4,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [CTL_W-1:0]  a_ctl,
    input  logic              b_vld,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [CTL_W-1:0]  b_ctl,
    input  logic              a_ready,
    input  logic              b_ready,
    input  logic              recov_mode,
    input  logic [LEN_W-1:0]  recov_len,
    output logic              sys_vld,
    output logic [ADDR_W-1:0] sys_addr,
    output logic [DATA_W-1:0] sys_wdata,
    output logic [CTL_W-1:0]  sys_ctl,
    output logic              core_halt,
    output logic              core_rollback,
    output logic              core_reboot,
    output logic [CNT_W-1:0]  err_count,
    output logic              chk_fault
);
    localparam int BUS_W  = ADDR_W + DATA_W + CTL_W;
    localparam int COPIES = 3;

    logic [BUS_W-1:0] a_bus, b_bus;
    assign a_bus = {a_addr, a_wdata, a_ctl};
    assign b_bus = {b_addr, b_wdata, b_ctl};

    logic [COPIES-1:0]            mm_c;
    logic [COPIES-1:0][1:0]       st_c;
    logic [COPIES-1:0][LEN_W-1:0] cnt_c;
    logic [COPIES-1:0]            mode_c;

    logic             mm_v;
    logic [1:0]       st_bits;
    lsg_state_e       st_v;
    logic [LEN_W-1:0] cnt_v;
    logic             mode_v;

    // Majority voters
    assign mm_v    = (mm_c[0] & mm_c[1]) | (mm_c[0] & mm_c[2]) | (mm_c[1] & mm_c[2]);
    assign st_bits = (st_c[0] & st_c[1]) | (st_c[0] & st_c[2]) | (st_c[1] & st_c[2]);
    assign st_v    = lsg_state_e'(st_bits);
    assign cnt_v   = (cnt_c[0] & cnt_c[1]) | (cnt_c[0] & cnt_c[2]) | (cnt_c[1] & cnt_c[2]);
    assign mode_v  = (mode_c[0] & mode_c[1]) | (mode_c[0] & mode_c[2]) | (mode_c[1] & mode_c[2]);

    logic trip;
    assign trip = mm_v && (st_v == ST_RUN);

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        lsg_state_e st_q_g;

        lsg_cmp #(.W(BUS_W)) u_cmp (
            .a_vld (a_vld),
            .b_vld (b_vld),
            .a_bus (a_bus),
            .b_bus (b_bus),
            .mism  (mm_c[g])
        );

        lsg_ctrl #(.LEN_W(LEN_W)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .trip    (trip),
            .mode_in (recov_mode),
            .len_in  (recov_len),
            .rdy_ok  (a_ready && b_ready),
            .st_v    (st_v),
            .cnt_v   (cnt_v),
            .mode_v  (mode_v),
            .st_q    (st_q_g),
            .cnt_q   (cnt_c[g]),
            .mode_q  (mode_c[g])
        );

        assign st_c[g] = st_q_g;
    end

    // Any disagreement among replicas is a checker fault
    assign chk_fault = (mm_c[0] != mm_c[1]) || (mm_c[0] != mm_c[2])
                    || (st_c[0] != st_c[1]) || (st_c[0] != st_c[2])
                    || (cnt_c[0] != cnt_c[1]) || (cnt_c[0] != cnt_c[2])
                    || (mode_c[0] != mode_c[1]) || (mode_c[0] != mode_c[2]);

    logic              pass;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;
    logic [CTL_W-1:0]  hold_ctl;
    logic [CNT_W-1:0]  err_q;

    // Output decode from the voted state
    always_comb begin
        pass          = 1'b0;
        core_halt     = 1'b0;
        core_rollback = 1'b0;
        core_reboot   = 1'b0;
        unique case (st_v)
            ST_RUN: begin
                core_halt = mm_v;
                pass      = a_vld && !mm_v;
            end
            ST_HALT: begin
                core_halt = 1'b1;
            end
            ST_RECOVER: begin
                core_rollback = !mode_v;
                core_reboot   = mode_v;
            end
            ST_RESYNC: begin
                core_halt = 1'b0;
            end
            default: core_halt = 1'b1;
        endcase
    end

    assign sys_vld   = pass;
    assign sys_addr  = pass ? a_addr  : hold_addr;
    assign sys_wdata = pass ? a_wdata : hold_wdata;
    assign sys_ctl   = pass ? a_ctl   : hold_ctl;
    assign err_count = err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_wdata <= '0;
            hold_ctl   <= '0;
            err_q      <= '0;
        end else begin
            if (pass) begin
                hold_addr  <= a_addr;
                hold_wdata <= a_wdata;
                hold_ctl   <= a_ctl;
            end
            if (trip && err_q != '1) err_q <= err_q + 1'b1;
        end
    end

    // R2
    halt_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v == ST_RUN && mm_c[0] && mm_c[1]) |-> (core_halt && !sys_vld));

    // R3
    held_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_vld) |=> (sys_vld || ($stable(sys_addr) && $stable(sys_wdata) && $stable(sys_ctl))));

    // R5
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rollback && core_reboot));

    // R6
    count_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v != ST_RUN) |=> (err_count == $past(err_count)));

    // R7
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == '1) |=> (err_count == '1));

    // R8
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_fault);
endmodule

// File: tb/lockstep_guard_bench.sv
module lockstep_guard_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CTL_W  = 4;
    localparam int LEN_W  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              a_vld, b_vld, a_ready, b_ready, recov_mode;
    logic [ADDR_W-1:0] a_addr, b_addr;
    logic [DATA_W-1:0] a_wdata, b_wdata;
    logic [CTL_W-1:0]  a_ctl, b_ctl;
    logic [LEN_W-1:0]  recov_len;

    logic              sys_vld, core_halt, core_rollback, core_reboot, chk_fault;
    logic [ADDR_W-1:0] sys_addr;
    logic [DATA_W-1:0] sys_wdata;
    logic [CTL_W-1:0]  sys_ctl;
    logic [15:0]       err_count;

    logic              s_vld, s_halt, s_rb, s_rs, s_fault;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;
    logic [CTL_W-1:0]  s_ctl;
    logic [3:0]        s_err;

    lockstep_guard u_lockstep_guard (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_addr(a_addr), .a_wdata(a_wdata), .a_ctl(a_ctl),
        .b_vld(b_vld), .b_addr(b_addr), .b_wdata(b_wdata), .b_ctl(b_ctl),
        .a_ready(a_ready), .b_ready(b_ready),
        .recov_mode(recov_mode), .recov_len(recov_len),
        .sys_vld(sys_vld), .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_ctl(sys_ctl),
        .core_halt(core_halt), .core_rollback(core_rollback), .core_reboot(core_reboot),
        .err_count(err_count), .chk_fault(chk_fault)
    );

    lockstep_guard #(.CNT_W(4)) u_lockstep_guard_sat (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_addr(a_addr), .a_wdata(a_wdata), .a_ctl(a_ctl),
        .b_vld(b_vld), .b_addr(b_addr), .b_wdata(b_wdata), .b_ctl(b_ctl),
        .a_ready(a_ready), .b_ready(b_ready),
        .recov_mode(recov_mode), .recov_len(recov_len),
        .sys_vld(s_vld), .sys_addr(s_addr), .sys_wdata(s_wdata), .sys_ctl(s_ctl),
        .core_halt(s_halt), .core_rollback(s_rb), .core_reboot(s_rs),
        .err_count(s_err), .chk_fault(s_fault)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Bench reference model: 0 RUN, 1 HALT, 2 RECOVER, 3 RESYNC
    int          m_st = 0;
    int          m_cnt = 0;
    bit          m_mode = 0;
    int          m_errs = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [DATA_W-1:0] m_wdata = '0;
    logic [CTL_W-1:0]  m_ctl = '0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_mism();
        return (a_vld != b_vld) ||
               (a_vld && b_vld && ({a_addr, a_wdata, a_ctl} != {b_addr, b_wdata, b_ctl}));
    endfunction

    function automatic int f_sat(input int v, input int lim);
        return (v > lim) ? lim : v;
    endfunction

    task automatic drive_same(input bit v);
        a_vld = v; b_vld = v;
        a_addr = $urandom; a_wdata = $urandom; a_ctl = CTL_W'($urandom);
        b_addr = a_addr; b_wdata = a_wdata; b_ctl = a_ctl;
    endtask

    // Compare outputs against the model, then advance the model across the edge
    task automatic eval_cycle();
        bit mm, pass, ehalt, erb, ers;
        #1;
        mm = f_mism();
        pass = (m_st == 0) && a_vld && !mm;
        ehalt = ((m_st == 0) && mm) || (m_st == 1);
        erb = (m_st == 2) && !m_mode;
        ers = (m_st == 2) && m_mode;
        if (m_st == 0) check("R2 halt", 64'(core_halt), 64'(ehalt));
        else if (m_st == 1) check("R4 halt", 64'(core_halt), 64'(ehalt));
        else check("R6 halt", 64'(core_halt), 64'(ehalt));
        check("R3 vld", 64'(sys_vld), 64'(pass));
        check("R3 addr", 64'(sys_addr), 64'(pass ? a_addr : m_addr));
        check("R3 data", 64'({sys_wdata, sys_ctl}), 64'(pass ? {a_wdata, a_ctl} : {m_wdata, m_ctl}));
        check("R5 rollback", 64'(core_rollback), 64'(erb));
        check("R5 reboot", 64'(core_reboot), 64'(ers));
        check("R7 count", 64'(err_count), 64'(f_sat(m_errs, 65535)));
        check("R7 sat count", 64'(s_err), 64'(f_sat(m_errs, 15)));
        check("R8 fault", 64'({chk_fault, s_fault}), 64'(0));
        @(posedge clk);
        if (pass) begin m_addr = a_addr; m_wdata = a_wdata; m_ctl = a_ctl; end
        case (m_st)
            0: if (mm) begin m_st = 1; m_errs++; end
            1: begin m_st = 2; m_mode = recov_mode; m_cnt = (recov_len == 0) ? 1 : int'(recov_len); end
            2: if (m_cnt <= 1) m_st = 3; else m_cnt--;
            default: if (a_ready && b_ready) m_st = 0;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; a_ready = 1; b_ready = 1; recov_mode = 0; recov_len = 8'd2;
        drive_same(0);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R9 reset state
        check("R9 reset", 64'({sys_vld, core_halt, core_rollback, core_reboot, chk_fault}), 64'(0));
        check("R9 reset count", 64'(err_count), 64'(0));
        check("R9 reset hold", 64'(sys_addr), 64'(0));
        @(posedge clk);
        rst_n = 1;

        // R1 directed: invalid beats with differing data are ignored
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); drive_same(0); b_addr = ~a_addr; b_wdata = ~a_wdata;
            eval_cycle();
        end
        // R1 directed: valid beats matched then a control-only difference
        @(negedge clk); drive_same(1); eval_cycle();
        @(negedge clk); drive_same(1); b_ctl = ~a_ctl; recov_mode = 1; recov_len = 0;
        eval_cycle();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); drive_same(1); a_ready = (k >= 3); b_ready = 1; eval_cycle();
        end
        // R6: one core slow to become ready
        @(negedge clk); drive_same(1); a_vld = 0; recov_mode = 0; recov_len = 3; eval_cycle();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); drive_same(1); a_ready = 1; b_ready = (k >= 7); eval_cycle();
        end

        // Constrained random mix
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            drive_same(($urandom % 4) != 0);
            if ($urandom % 12 == 0) begin
                case ($urandom % 4)
                    0: b_addr[$urandom % ADDR_W] ^= 1'b1;
                    1: b_wdata[$urandom % DATA_W] ^= 1'b1;
                    2: b_ctl[$urandom % CTL_W] ^= 1'b1;
                    default: b_vld = ~a_vld;
                endcase
            end
            a_ready = ($urandom % 3) != 0;
            b_ready = ($urandom % 3) != 0;
            recov_mode = $urandom % 2;
            recov_len = LEN_W'($urandom % 6);
            eval_cycle();
        end
        // R7: the narrow counter has been driven into saturation
        check("R7 saturated", 64'(m_errs > 15), 64'(1));
        finish_run();
    end
endmodule